// File: doc/BRIEF.md
# Channel-Synchronous Gain Code Sequencer

This block keeps the per-channel gain codes for one antenna input. It hands them to the downstream power and phase converter in step with the spectral channels arriving from the transform stage. A channel counter is restarted by a synchronisation pulse and steps once per incoming sample. The counter addresses a 4-bit gain table and a companion 1-bit parity table. Each gain code comes out one cycle after its sample strobe, together with a polarisation flag, so that it lines up with the registered sample data.

Each gain read during normal operation is checked against its stored parity bit. A mismatch raises a sticky error flag that stays set until the host clears it. When the host raises the mode input, it takes over the table address. It can then write a gain code and its precomputed parity bit in one cycle, and read both back. While the host holds the tables, sample strobes and sync pulses have no effect and no parity checks take place.

Top module: `chan_gain_seq`

## Requirements
- R1: After reset, gainValid, parityErr, gainPol and gainOut are all 0, and the channel count is 0.
- R2: With hostMode low, a sampleValid cycle reads the gain entry at the current channel count. That code appears on gainOut with gainValid high in the next cycle, and the count then advances by one.
- R3: A syncPulse with hostMode low restarts the count. A sample in the same cycle reads channel 0 and the following sample reads channel 1. A sync pulse without a sample sets the count to 0.
- R4: The channel count wraps from 2^ADDR_W-1 (1023 by default) to 0.
- R5: gainPol, valid with gainValid, equals bit 0 of the channel number that was read: 0 for even channels, 1 for odd channels.
- R6: With hostMode high, hostWrEn writes hostWrGain and hostWrPar into entry hostAddr of both tables in the same cycle.
- R7: With hostMode high, hostRdEn reads entry hostAddr. In the next cycle hostRdData carries the stored parity bit in bit 4 and the gain code in bits 3:0.
- R8: While hostMode is high, sampleValid and syncPulse are ignored: gainValid stays low and the channel count holds.
- R9: The stored parity is even parity: a correct bit equals the XOR of the 4 gain bits. If an operational read returns a parity bit that differs from this, parityErr goes high in the cycle after its gainValid.
- R10: parityErr stays high until errClear is asserted, and it is low in the cycle after a clear. If a mismatch and errClear occur in the same cycle, the flag is set.
- R11: Host reads never set parityErr, even of an entry with bad parity.
- R12: hostWrEn is ignored while hostMode is low. The entry keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncPulse | input | 1 | Restarts the channel count |
| sampleValid | input | 1 | One spectral sample arrives this cycle |
| hostMode | input | 1 | Host owns the table address |
| hostAddr | input | ADDR_W | Host table address |
| hostWrEn | input | 1 | Host write strobe |
| hostWrGain | input | GAIN_W | Gain code to write |
| hostWrPar | input | 1 | Precomputed parity bit to write |
| hostRdEn | input | 1 | Host read strobe |
| errClear | input | 1 | Clears the sticky parity error |
| hostRdData | output | GAIN_W+1 | {parity, gain} from the last host read |
| gainOut | output | GAIN_W | Gain code for the previous cycle's sample |
| gainValid | output | 1 | gainOut is valid |
| gainPol | output | 1 | Polarisation (channel bit 0) of gainOut |
| parityErr | output | 1 | Sticky parity error flag |

## Verification
The bench builds the block with its default parameters: a 10-bit address and 4-bit gain codes. With these values the full 1024-entry table can be loaded and read within a few thousand cycles. The same build lets a run of more than 1024 samples after a sync carry the counter through its wrap from 1023 to 0. The bench plants one entry with bad parity to drive the error flag through set, hold, clear and the case where set and clear coincide.

// File: rtl/gain_seq_pkg.sv
package gain_seq_pkg;
  typedef struct packed {
    logic wrEn;    // commit host write to both tables
    logic rdEn;    // load read registers from the tables
    logic opRead;  // the read is an operational (sample) read
  } seqStrobes_t;
endpackage

// File: rtl/gain_seq_ctrl.sv
module gain_seq_ctrl
  import gain_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncPulse,
  input  logic              sampleValid,
  input  logic              hostMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              errClear,
  input  logic              parMismatch,
  output seqStrobes_t       strobes,
  output logic [ADDR_W-1:0] tblAddr,
  output logic              parityErr
);
  logic [ADDR_W-1:0] chanCnt;
  logic [ADDR_W-1:0] opAddr;

  // A sync in the same cycle as a sample makes that sample channel 0
  assign opAddr  = syncPulse ? '0 : chanCnt;
  assign tblAddr = hostMode ? hostAddr : opAddr;

  always_comb begin
    strobes.wrEn   = hostMode & hostWrEn;
    strobes.opRead = ~hostMode & sampleValid;
    strobes.rdEn   = hostMode ? hostRdEn : sampleValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanCnt <= '0;
    end else if (!hostMode) begin
      if (sampleValid)    chanCnt <= opAddr + ADDR_W'(1);
      else if (syncPulse) chanCnt <= '0;
    end
  end

  // Sticky flag; a new mismatch wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parityErr <= 1'b0;
    else       parityErr <= parMismatch | (parityErr & ~errClear);
  end
endmodule

// File: rtl/gain_seq_dpath.sv
module gain_seq_dpath
  import gain_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [GAIN_W-1:0] wrGain,
  input  logic              wrPar,
  output logic [GAIN_W-1:0] rdGain,
  output logic              rdPar,
  output logic              opValid,
  output logic              opPol,
  output logic              parMismatch
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [GAIN_W-1:0] gainMem [DEPTH];
  logic              parMem  [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      gainMem[tblAddr] <= wrGain;
      parMem[tblAddr]  <= wrPar;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdGain  <= '0;
      rdPar   <= 1'b0;
      opValid <= 1'b0;
      opPol   <= 1'b0;
    end else begin
      opValid <= strobes.opRead;
      if (strobes.rdEn) begin
        rdGain <= gainMem[tblAddr];
        rdPar  <= parMem[tblAddr];
      end
      if (strobes.opRead) opPol <= tblAddr[0];
    end
  end

  // Even parity: stored bit must equal the XOR of the gain bits
  assign parMismatch = opValid & ((^rdGain) != rdPar);
endmodule

// File: rtl/chan_gain_seq.sv
module chan_gain_seq
  import gain_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int GAIN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncPulse,
  input  logic              sampleValid,
  input  logic              hostMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [GAIN_W-1:0] hostWrGain,
  input  logic              hostWrPar,
  input  logic              hostRdEn,
  input  logic              errClear,
  output logic [GAIN_W:0]   hostRdData,
  output logic [GAIN_W-1:0] gainOut,
  output logic              gainValid,
  output logic              gainPol,
  output logic              parityErr
);
  seqStrobes_t       strobes;
  logic [ADDR_W-1:0] tblAddr;
  logic [GAIN_W-1:0] rdGain;
  logic              rdPar;
  logic              parMismatch;

  gain_seq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .sampleValid(sampleValid),
    .hostMode(hostMode), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .errClear(errClear), .parMismatch(parMismatch),
    .strobes(strobes), .tblAddr(tblAddr), .parityErr(parityErr)
  );

  gain_seq_dpath #(.ADDR_W(ADDR_W), .GAIN_W(GAIN_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tblAddr(tblAddr),
    .wrGain(hostWrGain), .wrPar(hostWrPar), .rdGain(rdGain), .rdPar(rdPar),
    .opValid(gainValid), .opPol(gainPol), .parMismatch(parMismatch)
  );

  assign gainOut    = rdGain;
  assign hostRdData = {rdPar, rdGain};
endmodule

// File: rtl/chan_gain_seq_chk.sv
module chan_gain_seq_chk (
  input logic clk,
  input logic rstN,
  input logic hostMode,
  input logic sampleValid,
  input logic syncPulse,
  input logic errClear,
  input logic gainValid,
  input logic gainPol,
  input logic parityErr
);
  a_r2_valid_follows_sample: assert property (@(posedge clk) disable iff (!rstN)
    (!hostMode && sampleValid) |=> gainValid);

  a_r8_host_blocks_valid: assert property (@(posedge clk) disable iff (!rstN)
    hostMode |=> !gainValid);

  a_r3_sync_reads_even: assert property (@(posedge clk) disable iff (!rstN)
    (!hostMode && sampleValid && syncPulse) |=> (gainValid && !gainPol));

  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !errClear) |=> parityErr);

  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && !gainValid) |=> !parityErr);

  a_r9_err_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(gainValid));
endmodule

bind chan_gain_seq chan_gain_seq_chk uChk (
  .clk(clk), .rstN(rstN), .hostMode(hostMode), .sampleValid(sampleValid),
  .syncPulse(syncPulse), .errClear(errClear), .gainValid(gainValid),
  .gainPol(gainPol), .parityErr(parityErr)
);

// File: tb/tb_chan_gain_seq.sv
`timescale 1ns/1ps
module tb_chan_gain_seq;
  localparam int AW = 10;
  localparam int GW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncPulse = 0, sampleValid = 0, hostMode = 0, hostWrEn = 0;
  logic hostWrPar = 0, hostRdEn = 0, errClear = 0;
  logic [AW-1:0] hostAddr = '0;
  logic [GW-1:0] hostWrGain = '0;
  logic [GW:0]   hostRdData;
  logic [GW-1:0] gainOut;
  logic gainValid, gainPol, parityErr;

  int checks = 0;
  int errors = 0;
  logic [GW-1:0] mGain [DEPTH];
  logic          mPar  [DEPTH];
  int expCnt = 0;
  logic [GW:0] expQ [$];   // {pol, gain}

  always #4 clk = ~clk;  // 125 MHz

  chan_gain_seq #(.ADDR_W(AW), .GAIN_W(GW)) dut (
    .clk(clk), .rstN(rstN), .syncPulse(syncPulse), .sampleValid(sampleValid),
    .hostMode(hostMode), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrGain(hostWrGain), .hostWrPar(hostWrPar), .hostRdEn(hostRdEn),
    .errClear(errClear), .hostRdData(hostRdData), .gainOut(gainOut),
    .gainValid(gainValid), .gainPol(gainPol), .parityErr(parityErr)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] patGain(int a);
    return GW'((a * 5 + (a >> 4)) & 15);
  endfunction

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic hostWrite(int a, logic [GW-1:0] g, logic p);
    hostMode = 1; hostWrEn = 1; hostAddr = AW'(a); hostWrGain = g; hostWrPar = p;
    @(posedge clk); #1;
    hostWrEn = 0;
    mGain[a] = g; mPar[a] = p;
  endtask

  task automatic hostRead(int a, string tag);
    hostMode = 1; hostRdEn = 1; hostAddr = AW'(a);
    @(posedge clk); #1;
    hostRdEn = 0;
    @(negedge clk);
    check(tag, int'(hostRdData), int'({mPar[a], mGain[a]}));
    @(posedge clk); #1;
  endtask

  // Driver: one operational sample, pushes the expected result
  task automatic sampleTick(logic sync);
    int a;
    hostMode = 0; sampleValid = 1; syncPulse = sync;
    a = sync ? 0 : expCnt;
    expQ.push_back({a[0], mGain[a]});
    expCnt = (a + 1) % DEPTH;
    @(posedge clk); #1;
    sampleValid = 0; syncPulse = 0;
  endtask

  // Monitor: compares every gainValid cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && gainValid) begin
      logic [GW:0] e;
      if (expQ.size() == 0) begin
        check("R8 unexpected gainValid", 1, 0);
      end else begin
        e = expQ.pop_front();
        check("R2 gainOut", int'(gainOut), int'(e[GW-1:0]));
        check("R5 gainPol", int'(gainPol), int'(e[GW]));
      end
    end
  end

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 gainValid", int'(gainValid), 0);
    check("R1 parityErr", int'(parityErr), 0);
    check("R1 gainOut", int'(gainOut), 0);
    check("R1 gainPol", int'(gainPol), 0);
    rstN = 1;
    idle();
    // R1: count is 0 after reset, first plain sample reads channel 0
    sampleTick(0);
    idle();

    // R6: load every entry with correct even parity
    for (int a = 0; a < DEPTH; a++) hostWrite(a, patGain(a), ^patGain(a));
    hostRead(0, "R7 readback ch0");
    hostRead(7, "R7 readback ch7");
    hostRead(DEPTH - 1, "R7 readback last");
    hostWrite(12, 4'b1011, 1'b1);
    hostRead(12, "R6 rewrite both tables");

    // R2/R3/R5: sync with sample, then a run of samples
    sampleTick(1);
    for (int i = 0; i < 20; i++) sampleTick(0);
    idle();
    // R3: sync alone, then samples start at channel 0
    hostMode = 0; syncPulse = 1; idle(); syncPulse = 0;
    expCnt = 0;
    for (int i = 0; i < 5; i++) sampleTick(0);
    idle();
    check("R9 no error on good parity", int'(parityErr), 0);

    // R4: run past the wrap
    sampleTick(1);
    for (int i = 0; i < DEPTH + 6; i++) sampleTick(0);
    idle(); idle();

    // R8: host mode ignores samples and sync; count holds
    hostMode = 1; sampleValid = 1; syncPulse = 1; idle(); idle();
    sampleValid = 0; syncPulse = 0; idle();
    check("R8 no gainValid in host mode", int'(gainValid), 0);
    sampleTick(0);
    idle();

    // R12: write without host mode is ignored
    hostMode = 0; hostWrEn = 1; hostAddr = 9; hostWrGain = ~mGain[9]; hostWrPar = ~mPar[9];
    idle(); hostWrEn = 0;
    hostRead(9, "R12 entry unchanged");

    // R11: bad parity entry read by host does not set the flag
    hostWrite(3, patGain(3), ~(^patGain(3)));
    hostRead(3, "R11 readback bad entry");
    idle();
    check("R11 host read no error", int'(parityErr), 0);

    // R9: operational read of the bad entry
    sampleTick(1); sampleTick(0); sampleTick(0); sampleTick(0);
    idle();
    @(negedge clk);
    check("R9 error set", int'(parityErr), 1);
    @(posedge clk); #1;
    sampleTick(0); sampleTick(0); sampleTick(0);
    idle(); idle();
    check("R10 error sticky", int'(parityErr), 1);
    errClear = 1; idle(); errClear = 0;
    check("R10 error cleared", int'(parityErr), 0);

    // R10: mismatch and clear in the same cycle -> set wins
    sampleTick(1); sampleTick(0); sampleTick(0); sampleTick(0);
    errClear = 1; idle(); errClear = 0;
    check("R10 set wins over clear", int'(parityErr), 1);
    errClear = 1; idle(); errClear = 0;
    check("R10 cleared again", int'(parityErr), 0);

    repeat (4) idle();
    check("R2 scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule